// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This block is the multiply and divide engine of a small 32-bit load/store core. It holds two architectural result registers, HI and LO, and performs signed and unsigned multiplication, signed and unsigned division, and direct register moves. The core presents an operation code, two operands and a one-cycle start strobe. Long operations raise `busy` until their results are committed, and `done` pulses for one cycle when any accepted operation has taken effect.

A multiplication builds its double-width product from four half-width partial products. These are registered in one cycle and summed in the next, with the middle column's carry folded explicitly into the upper word. Division is a restoring divider on operand magnitudes that yields one quotient bit per cycle, followed by a sign-fix cycle. A zero divisor gives zero in both result registers. Move-from operations copy HI or LO onto `rd_data`. The core must hold a request until `busy` is low, because a start seen while busy is dropped.

Top module: `hilo_muldiv`

## Requirements
- R1: Op code 0 (signed multiply) writes bits 63:32 of the two's-complement product of `opa` and `opb` to HI and bits 31:0 to LO.
- R2: Op code 1 (unsigned multiply) writes the upper and lower words of the unsigned 64-bit product to HI and LO.
- R3: Op code 2 (signed divide) with a nonzero divisor writes the quotient truncated toward zero to LO and the remainder, carrying the sign of the dividend, to HI. The most negative value divided by -1 gives LO = 0x80000000 and HI = 0.
- R4: Op code 3 (unsigned divide) with a nonzero divisor writes the unsigned quotient to LO and the remainder to HI.
- R5: A zero `opb` with op code 2 or 3 sets both HI and LO to zero.
- R6: Op code 4 copies `opa` into HI and op code 5 copies `opa` into LO, at the accepting edge. `busy` stays low and `done` is high for the following cycle.
- R7: Op code 6 places HI and op code 7 places LO on `rd_data` at the accepting edge, with `done` high for the following cycle and HI/LO unchanged.
- R8: After the accepting edge, `busy` is high for exactly 2 cycles for a multiply and 33 cycles for a divide. Results appear and `done` is high in the first cycle with `busy` low.
- R9: A `start` seen while `busy` is high is ignored. HI and LO change only as the result of an accepted operation.
- R10: While reset is low, HI, LO and `rd_data` read zero and `busy` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted only when not busy |
| op | input | 3 | Operation code 0..7 |
| opa | input | 32 | First operand: multiplicand, dividend or move source |
| opb | input | 32 | Second operand: multiplier or divisor |
| hi | output | 32 | HI register |
| lo | output | 32 | LO register |
| rd_data | output | 32 | Result of the last move-from |
| busy | output | 1 | Multiply or divide in progress |
| done | output | 1 | One-cycle pulse after any accepted operation takes effect |

## Verification
The bench targets the sign corners of the split multiplier: the most negative value squared, -1 times -1, and all-ones unsigned. A design that mishandled sign extension of the upper halves or dropped the middle-column carry would produce a wrong HI word. Division covers every sign pairing, the most-negative-over-minus-one overflow and zero divisors for both signed and unsigned divide. A divider that took the remainder's sign from the divisor or rounded toward minus infinity would differ in HI or LO. A move-to request is injected in the middle of a division; a unit that accepted it would corrupt HI or shorten the busy window.

// File: rtl/hilo_pkg.sv
package hilo_pkg;
   typedef enum logic [2:0] {
      OP_MULS  = 3'd0,
      OP_MULU  = 3'd1,
      OP_DIVS  = 3'd2,
      OP_DIVU  = 3'd3,
      OP_SETHI = 3'd4,
      OP_SETLO = 3'd5,
      OP_GETHI = 3'd6,
      OP_GETLO = 3'd7
   } md_op_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_MPP  = 3'd1,
      ST_MSUM = 3'd2,
      ST_DIV  = 3'd3,
      ST_DFIN = 3'd4
   } md_state_e;
endpackage

// File: rtl/hilo_pp_gen.sv
module hilo_pp_gen #(
   parameter int W = 32
) (
   input  logic                   sgn,
   input  logic [W-1:0]           a,
   input  logic [W-1:0]           b,
   output logic signed [W+1:0]    pp [4]
);
   localparam int H  = W / 2;
   localparam int PW = 2 * H + 2;

   logic signed [H:0] a_half [2];
   logic signed [H:0] b_half [2];

   // index 0 = low half (zero extended), 1 = high half (signed when sgn)
   assign a_half[0] = {1'b0, a[H-1:0]};
   assign a_half[1] = {sgn & a[W-1], a[W-1:H]};
   assign b_half[0] = {1'b0, b[H-1:0]};
   assign b_half[1] = {sgn & b[W-1], b[W-1:H]};

   // pp[i]: i[1] selects the half of a, i[0] selects the half of b
   for (genvar i = 0; i < 4; i++) begin : g_pp
      logic signed [PW-1:0] xe, ye;
      assign xe    = PW'(a_half[i / 2]);
      assign ye    = PW'(b_half[i % 2]);
      assign pp[i] = xe * ye;
   end
endmodule

// File: rtl/hilo_pp_sum.sv
module hilo_pp_sum #(
   parameter int W = 32
) (
   input  logic signed [W+1:0] pp [4],
   output logic [W-1:0]        prod_hi,
   output logic [W-1:0]        prod_lo
);
   localparam int H  = W / 2;
   localparam int MW = W + 3;

   logic signed [MW-1:0] mid;
   logic signed [MW-1:0] mid_sh;

   // middle column: both cross products plus the carry half of the low product
   assign mid     = MW'(pp[1]) + MW'(pp[2]) + MW'(pp[0] >>> H);
   assign mid_sh  = mid >>> H;
   assign prod_lo = {mid[H-1:0], pp[0][H-1:0]};
   assign prod_hi = W'(pp[3]) + W'(mid_sh);
endmodule

// File: rtl/hilo_div_seq.sv
module hilo_div_seq #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         step,
   input  logic [W-1:0] dvd,
   input  logic [W-1:0] dvs,
   output logic [W-1:0] quo,
   output logic [W-1:0] rem
);
   logic [W-1:0] q_q, r_q, d_q;
   logic [W:0]   trial;
   logic [W:0]   diff;

   assign trial = {r_q, q_q[W-1]};
   assign diff  = trial - {1'b0, d_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_q <= '0;
         r_q <= '0;
         d_q <= '0;
      end else if (load) begin
         q_q <= dvd;
         r_q <= '0;
         d_q <= dvs;
      end else if (step) begin
         r_q <= diff[W] ? trial[W-1:0] : diff[W-1:0];
         q_q <= {q_q[W-2:0], ~diff[W]};
      end
   end

   assign quo = q_q;
   assign rem = r_q;
endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv #(
   parameter int W      = 32,
   parameter bit PP_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic [2:0]   op,
   input  logic [W-1:0] opa,
   input  logic [W-1:0] opb,
   output logic [W-1:0] hi,
   output logic [W-1:0] lo,
   output logic [W-1:0] rd_data,
   output logic         busy,
   output logic         done
);
   import hilo_pkg::*;

   localparam int CW = $clog2(W);

   if ((W % 2) != 0 || W < 4) begin : g_bad_width
      $error("hilo_muldiv: W must be even and at least 4");
   end

   md_state_e     st_q;
   logic [W-1:0]  a_q, b_q;
   logic          sgn_q;
   logic [CW-1:0] cnt_q;
   logic          negq_q, negr_q, dz_q;
   logic [W-1:0]  hi_q, lo_q, rd_q;
   logic          done_q;

   md_op_e        opc;
   logic          idle, accept;
   logic          div_load, div_step, sdiv;
   logic [W-1:0]  mag_a, mag_b, quo, rem;
   logic signed [W+1:0] pp_c [4];
   logic signed [W+1:0] pp_u [4];
   logic [W-1:0]  prod_hi, prod_lo;

   assign opc    = md_op_e'(op);
   assign idle   = (st_q == ST_IDLE);
   assign accept = idle && start;
   assign sdiv   = (opc == OP_DIVS);
   assign mag_a  = (sdiv && opa[W-1]) ? -opa : opa;
   assign mag_b  = (sdiv && opb[W-1]) ? -opb : opb;
   assign div_load = accept && (opc == OP_DIVS || opc == OP_DIVU);
   assign div_step = (st_q == ST_DIV);

   hilo_pp_gen #(.W(W)) u_ppg (
      .sgn (sgn_q),
      .a   (a_q),
      .b   (b_q),
      .pp  (pp_c)
   );

   if (PP_REG) begin : g_pp_reg
      logic signed [W+1:0] pp_q [4];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int i = 0; i < 4; i++) pp_q[i] <= '0;
         end else if (st_q == ST_MPP) begin
            for (int i = 0; i < 4; i++) pp_q[i] <= pp_c[i];
         end
      end
      assign pp_u = pp_q;
   end else begin : g_pp_comb
      assign pp_u = pp_c;
   end

   hilo_pp_sum #(.W(W)) u_pps (
      .pp      (pp_u),
      .prod_hi (prod_hi),
      .prod_lo (prod_lo)
   );

   hilo_div_seq #(.W(W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (div_load),
      .step  (div_step),
      .dvd   (mag_a),
      .dvs   (mag_b),
      .quo   (quo),
      .rem   (rem)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         a_q    <= '0;
         b_q    <= '0;
         sgn_q  <= 1'b0;
         cnt_q  <= '0;
         negq_q <= 1'b0;
         negr_q <= 1'b0;
         dz_q   <= 1'b0;
         hi_q   <= '0;
         lo_q   <= '0;
         rd_q   <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  unique case (opc)
                     OP_MULS, OP_MULU: begin
                        a_q   <= opa;
                        b_q   <= opb;
                        sgn_q <= (opc == OP_MULS);
                        st_q  <= PP_REG ? ST_MPP : ST_MSUM;
                     end
                     OP_DIVS, OP_DIVU: begin
                        negq_q <= sdiv && (opa[W-1] ^ opb[W-1]);
                        negr_q <= sdiv && opa[W-1];
                        dz_q   <= (opb == '0);
                        cnt_q  <= '0;
                        st_q   <= ST_DIV;
                     end
                     OP_SETHI: begin
                        hi_q   <= opa;
                        done_q <= 1'b1;
                     end
                     OP_SETLO: begin
                        lo_q   <= opa;
                        done_q <= 1'b1;
                     end
                     OP_GETHI: begin
                        rd_q   <= hi_q;
                        done_q <= 1'b1;
                     end
                     OP_GETLO: begin
                        rd_q   <= lo_q;
                        done_q <= 1'b1;
                     end
                     default: ;
                  endcase
               end
            end
            ST_MPP: st_q <= ST_MSUM;
            ST_MSUM: begin
               hi_q   <= prod_hi;
               lo_q   <= prod_lo;
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            ST_DIV: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == CW'(W - 1)) st_q <= ST_DFIN;
            end
            ST_DFIN: begin
               if (dz_q) begin
                  hi_q <= '0;
                  lo_q <= '0;
               end else begin
                  hi_q <= negr_q ? -rem : rem;
                  lo_q <= negq_q ? -quo : quo;
               end
               done_q <= 1'b1;
               st_q   <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign hi      = hi_q;
   assign lo      = lo_q;
   assign rd_data = rd_q;
   assign busy    = !idle;
   assign done    = done_q;
endmodule

// File: rtl/hilo_chk.sv
module hilo_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic         start,
   input logic [2:0]   op,
   input logic [W-1:0] opa,
   input logic [W-1:0] hi,
   input logic [W-1:0] lo,
   input logic [W-1:0] rd_data,
   input logic         busy,
   input logic         done
);
   int unsigned run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) run_len <= 0;
      else        run_len <= busy ? run_len + 1 : 0;
   end

   // R6
   sethi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op == 3'd4) |=> (hi == $past(opa)) && done && !busy);

   // R6
   setlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op == 3'd5) |=> (lo == $past(opa)) && done && !busy);

   // R7
   gethi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op == 3'd6) |=> (rd_data == $past(hi)) && done);

   // R7
   getlo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op == 3'd7) |=> (rd_data == $past(lo)) && done);

   // R8
   long_op_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start && op[2] == 1'b0) |=> busy);

   // R8
   done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   // R8
   run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_len <= W + 1);

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(hi) && $stable(lo));

   // R8
   done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

bind hilo_muldiv hilo_chk #(.W(W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .op      (op),
   .opa     (opa),
   .hi      (hi),
   .lo      (lo),
   .rd_data (rd_data),
   .busy    (busy),
   .done    (done)
);

// File: tb/sim_hilo_muldiv.sv
`timescale 1ns/1ps
module sim_hilo_muldiv;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [2:0]  op = 3'd0;
   logic [31:0] opa = '0, opb = '0;
   logic [31:0] hi, lo, rd_data;
   logic        busy, done;

   always #4 clk = ~clk;

   hilo_muldiv u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .opa(opa), .opb(opb),
      .hi(hi), .lo(lo), .rd_data(rd_data), .busy(busy), .done(done)
   );

   int checks = 0, failures = 0;
   bit finished = 1'b0;
   string cur_req = "R10";

   logic [31:0] m_hi, m_lo, m_rd, p_hi, p_lo;
   int          m_cnt;
   bit          m_done;

   task automatic expect_res(input logic [2:0] o, input logic [31:0] a, b,
                             output logic [31:0] h, l);
      longint      sa, sb, sq, sr;
      logic [63:0] pr;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      case (o)
         3'd0: begin pr = 64'(sa * sb); h = pr[63:32]; l = pr[31:0]; end
         3'd1: begin pr = {32'd0, a} * {32'd0, b}; h = pr[63:32]; l = pr[31:0]; end
         3'd2: begin
            if (b == 0) begin h = 0; l = 0; end
            else begin
               sq = sa / sb; sr = sa % sb;
               l = sq[31:0]; h = sr[31:0];
            end
         end
         default: begin
            if (b == 0) begin h = 0; l = 0; end
            else begin l = a / b; h = a % b; end
         end
      endcase
   endtask

   // reference model, advanced on every rising edge
   always @(posedge clk) begin
      if (!rst_n) begin
         m_hi = 0; m_lo = 0; m_rd = 0; m_cnt = 0; m_done = 0;
      end else begin
         m_done = 0;
         if (m_cnt > 0) begin
            m_cnt = m_cnt - 1;
            if (m_cnt == 0) begin m_hi = p_hi; m_lo = p_lo; m_done = 1; end
         end else if (start) begin
            case (op)
               3'd0, 3'd1: begin expect_res(op, opa, opb, p_hi, p_lo); m_cnt = 2; end
               3'd2, 3'd3: begin expect_res(op, opa, opb, p_hi, p_lo); m_cnt = 33; end
               3'd4: begin m_hi = opa; m_done = 1; end
               3'd5: begin m_lo = opa; m_done = 1; end
               3'd6: begin m_rd = m_hi; m_done = 1; end
               default: begin m_rd = m_lo; m_done = 1; end
            endcase
         end
      end
   end

   task automatic chk(input string what, input logic [31:0] act, exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      if (!finished) begin
         chk("hi", hi, m_hi);
         chk("lo", lo, m_lo);
         chk("rd_data", rd_data, m_rd);
         chk("busy", 32'(busy), 32'(m_cnt > 0));
         chk("done", 32'(done), 32'(m_done));
      end
   end

   task automatic run_op(input logic [2:0] o, input logic [31:0] a, b, input string tag);
      cur_req = tag;
      start = 1'b1; op = o; opa = a; opb = b;
      @(negedge clk);
      start = 1'b0;
      while (m_cnt > 0) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      logic [31:0] x;
      x = 32'h1234_5678;
      cur_req = "R10";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      run_op(3'd4, 32'hDEAD_BEEF, 0, "R6");
      run_op(3'd5, 32'h0BAD_F00D, 0, "R6");
      run_op(3'd6, 0, 0, "R7");
      run_op(3'd7, 0, 0, "R7");

      run_op(3'd0, 32'h0001_2345, 32'hFFFF_FF9C, "R1");
      run_op(3'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1");
      run_op(3'd0, 32'h8000_0000, 32'h8000_0000, "R1");
      run_op(3'd0, 32'h7FFF_FFFF, 32'h8000_0000, "R1");
      run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2");
      run_op(3'd1, 32'h8000_8000, 32'h0001_FFFF, "R2");

      run_op(3'd2, 32'd7, 32'hFFFF_FFFE, "R3");
      run_op(3'd2, 32'hFFFF_FFF9, 32'd2, "R3");
      run_op(3'd2, 32'hFFFF_FFF9, 32'hFFFF_FFFE, "R3");
      run_op(3'd2, 32'h8000_0000, 32'hFFFF_FFFF, "R3");
      run_op(3'd3, 32'hFFFF_FFFF, 32'd10, "R4");
      run_op(3'd3, 32'd5, 32'd9, "R4");

      run_op(3'd4, 32'h1111_1111, 0, "R5");
      run_op(3'd2, 32'h1234_5678, 32'd0, "R5");
      run_op(3'd4, 32'h2222_2222, 0, "R5");
      run_op(3'd3, 32'hFFFF_FFFF, 32'd0, "R5");

      // R8/R9: requests during a divide must be dropped
      cur_req = "R9";
      start = 1'b1; op = 3'd3; opa = 32'd1000; opb = 32'd7;
      @(negedge clk);
      op = 3'd4; opa = 32'hAAAA_AAAA;
      repeat (3) @(negedge clk);
      op = 3'd0; opa = 32'h5;
      @(negedge clk);
      start = 1'b0;
      cur_req = "R8";
      while (m_cnt > 0) @(negedge clk);
      @(negedge clk);
      run_op(3'd7, 0, 0, "R7");

      for (int i = 0; i < 24; i++) begin
         logic [31:0] ya;
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         ya = x;
         x = x ^ (x << 13); x = x ^ (x >> 17); x = x ^ (x << 5);
         case (i % 4)
            0: run_op(3'd0, ya, x, "R1");
            1: run_op(3'd1, ya, x, "R2");
            2: run_op(3'd2, ya, x >> (i % 20), "R3");
            default: run_op(3'd3, ya, x >> (i % 28), "R4");
         endcase
      end
      run_op(3'd6, 0, 0, "R7");
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule